// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Controller

This block sits on a disk interface card that carries two drive channels. It gates each channel's interrupt request onto one combined interrupt line. It reports each channel's raw request in a status register. It steers the card's single DMA handshake to one of the channels, and it returns a fixed 4-bit card identity code. Software reaches it through a byte-wide port with an address, separate read and write strobes, and registered read data that is valid on the cycle after the read strobe.

Access type alone controls the interrupt enables. A write of any value to a channel's enable address turns that channel on. A read of the same address turns it off. The status registers show the drive request lines whether or not a channel is enabled, so software can poll a channel without taking its interrupt. A configuration byte at offset zero drives two outputs: one steers DMA, the other opens the extended register region. Writing zero to that byte returns the card to its power-up mapping.

Top module: `drvirq_ctrl`

## Requirements
- R1: After synchronous reset both interrupt enables are clear, the configuration byte is 0x00, `card_irq`, `dma_sel` and `ext_en` are 0, and `bus_rdata` is 0x00.
- R2: A write of any data to 0x2200 (channel 1) or 0x3200 (channel 2) sets that channel's enable from the next cycle on.
- R3: A read of a channel's enable address clears that channel's enable from the next cycle on and returns 0x00.
- R4: A read of 0x2290 (channel 1) or 0x3290 (channel 2) returns, on the cycle after the strobe, bit 0 equal to that channel's `drv_req` line at the strobe edge, whatever the enable state, with bits 7..1 zero.
- R5: `card_irq` is high, without a register delay, exactly when some channel has both its `drv_req` bit and its enable set.
- R6: A write to 0x0000 stores the whole byte, and a read of 0x0000 returns it. Bit 0 drives `dma_sel` (1 selects channel 2, 0 selects channel 1), and bit 5 drives `ext_en`. Writing 0x00 returns both outputs to 0.
- R7: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return identity bits 0, 1, 2 and 3 of `ID_CODE` in bit 0, with the other bits zero. The default code is 4'b0011.
- R8: If a channel's request rises in the same cycle as a read of its enable address, the enable is still cleared and `card_irq` stays low. A later status read still returns 1.
- R9: A read of any other offset returns 0x00 and changes neither enable nor the configuration byte.
- R10: When the write and read strobes are both high, the access counts as a write. At an enable address this sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| drv_req | input | 2 | Raw interrupt requests, bit 0 channel 1, bit 1 channel 2 |
| card_irq | output | 1 | Combined gated interrupt |
| dma_sel | output | 1 | DMA handshake route, 1 = channel 2 |
| ext_en | output | 1 | Extended register region enable |

## Verification
The bench goes after the side-effect corners of the register map. A read of an enable address must disable and not enable. A design that decoded only the address would leave the interrupt asserted. It also checks that the status read ignores the enable, since a design that gated status would read 0 while a drive waits. The request that arrives in the same cycle as a disabling read is checked, along with a strobe collision and a read of an unmapped offset, because a loose decode or a wrong priority would flip an enable there. The identity bit order is checked so that a reversed index would show up as 4'b1100.

// File: rtl/drvirq_pkg.sv
package drvirq_pkg;
    localparam int ADDR_W   = 14;
    localparam int DATA_W   = 8;
    localparam int NCH      = 2;
    localparam int ID_BITS  = 4;
    localparam int ID_IDX_W = $clog2(ID_BITS);

    localparam logic [ADDR_W-1:0] CFG_ADDR = 14'h0000;
    localparam logic [ADDR_W-1:0] ID_BASE  = 14'h2280;
    localparam int CFG_EXT_BIT = 5;
    localparam int CFG_DMA_BIT = 0;

    typedef enum logic [1:0] {ACC_IDLE, ACC_WR, ACC_RD} acc_e;

    typedef struct packed {
        logic                cfg;
        logic [NCH-1:0]      en;
        logic [NCH-1:0]      stat;
        logic                id;
        logic [ID_IDX_W-1:0] id_idx;
    } hit_t;

    function automatic logic [ADDR_W-1:0] chan_en_addr(input int ch);
        return (ch == 0) ? 14'h2200 : 14'h3200;
    endfunction

    function automatic logic [ADDR_W-1:0] chan_stat_addr(input int ch);
        return chan_en_addr(ch) + 14'h0090;
    endfunction
endpackage

// File: rtl/drvirq_decode.sv
module drvirq_decode
    import drvirq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int ID_LSB = ID_IDX_W + 2;

    always_comb begin
        hit = '0;
        hit.cfg = (addr == CFG_ADDR);
        for (int c = 0; c < NCH; c++) begin
            hit.en[c]   = (addr == chan_en_addr(c));
            hit.stat[c] = (addr == chan_stat_addr(c));
        end
        hit.id     = (addr[ADDR_W-1:ID_LSB] == ID_BASE[ADDR_W-1:ID_LSB]) && (addr[1:0] == 2'b00);
        hit.id_idx = addr[ID_LSB-1:2];
    end
endmodule

// File: rtl/drvirq_chan.sv
module drvirq_chan
    import drvirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_e acc,
    input  logic hit_en,
    input  logic req,
    output logic irq_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)                              en_q <= 1'b0;
        else if (hit_en && acc == ACC_WR)     en_q <= 1'b1;
        else if (hit_en && acc == ACC_RD)     en_q <= 1'b0;
    end

    assign irq_o = en_q & req;

    a_r2_write_enables: assert property (@(posedge clk) disable iff (rst)
        (hit_en && acc == ACC_WR) |=> en_q);
    a_r3_read_disables: assert property (@(posedge clk) disable iff (rst)
        (hit_en && acc == ACC_RD) |=> !en_q);
    a_r9_enable_holds: assert property (@(posedge clk) disable iff (rst)
        !(hit_en && acc != ACC_IDLE) |=> $stable(en_q));
    a_r5_irq_needs_req: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> req);
endmodule

// File: rtl/drvirq_cfg.sv
module drvirq_cfg
    import drvirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)                          cfg_o <= '0;
        else if (hit && acc == ACC_WR)    cfg_o <= wdata;
    end

    a_r6_cfg_loads: assert property (@(posedge clk) disable iff (rst)
        (hit && acc == ACC_WR) |=> cfg_o == $past(wdata));
    a_r9_cfg_holds: assert property (@(posedge clk) disable iff (rst)
        !(hit && acc == ACC_WR) |=> $stable(cfg_o));
endmodule

// File: rtl/drvirq_ctrl.sv
module drvirq_ctrl
    import drvirq_pkg::*;
#(
    parameter logic [ID_BITS-1:0] ID_CODE = 4'b0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    drv_req,
    output logic              card_irq,
    output logic              dma_sel,
    output logic              ext_en
);
    acc_e              acc;
    hit_t              hit;
    logic [NCH-1:0]    irq_vec;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] rd_next;

    // write wins over read when both strobes are high (R10)
    assign acc = bus_wr ? ACC_WR : (bus_rd ? ACC_RD : ACC_IDLE);

    drvirq_decode u_decode (.addr(bus_addr), .hit(hit));

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        drvirq_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .acc    (acc),
            .hit_en (hit.en[c]),
            .req    (drv_req[c]),
            .irq_o  (irq_vec[c])
        );
    end

    drvirq_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .hit   (hit.cfg),
        .wdata (bus_wdata),
        .cfg_o (cfg_q)
    );

    assign card_irq = |irq_vec;
    assign dma_sel  = cfg_q[CFG_DMA_BIT];
    assign ext_en   = cfg_q[CFG_EXT_BIT];

    always_comb begin
        rd_next = '0;
        if (hit.cfg) rd_next = cfg_q;
        for (int c = 0; c < NCH; c++)
            if (hit.stat[c]) rd_next[0] = drv_req[c];
        if (hit.id) rd_next[0] = ID_CODE[hit.id_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)                 bus_rdata <= '0;
        else if (acc == ACC_RD)  bus_rdata <= rd_next;
    end

    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        card_irq |-> (drv_req != '0));
    a_r4_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && hit.stat != '0) |=> bus_rdata[DATA_W-1:1] == '0);
    a_r7_id_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && hit.id) |=> bus_rdata[DATA_W-1:1] == '0);
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && hit == '0) |=> bus_rdata == '0);
    a_r3_enable_read_zero: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && hit.en != '0) |=> bus_rdata == '0);
endmodule

// File: tb/test_drvirq_ctrl.sv
module test_drvirq_ctrl;
    localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [13:0] addr;
        logic [7:0]  wd;
        logic [1:0]  req;
        logic [7:0]  erd;
        logic        eirq;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 14'h2290, 8'h00, 2'b01, 8'h01, 1'b0, 8'd4},  // R4 status while disabled
        '{2'd1, 14'h2200, 8'hA5, 2'b01, 8'h00, 1'b1, 8'd2},  // R2 enable ch1
        '{2'd2, 14'h3290, 8'h00, 2'b10, 8'h01, 1'b0, 8'd5},  // R5 ch2 req, ch2 off
        '{2'd1, 14'h3200, 8'h00, 2'b10, 8'h00, 1'b1, 8'd2},  // R2 enable ch2
        '{2'd0, 14'h0000, 8'h00, 2'b00, 8'h00, 1'b0, 8'd5},  // R5 no req
        '{2'd2, 14'h2200, 8'h00, 2'b11, 8'h00, 1'b1, 8'd3},  // R3 disable ch1
        '{2'd0, 14'h0000, 8'h00, 2'b01, 8'h00, 1'b0, 8'd3},  // R3 ch1 now gated
        '{2'd2, 14'h3200, 8'h00, 2'b11, 8'h00, 1'b0, 8'd3},  // R3 disable ch2
        '{2'd1, 14'h0000, 8'h21, 2'b00, 8'h00, 1'b0, 8'd6},  // R6 cfg write
        '{2'd2, 14'h0000, 8'h00, 2'b00, 8'h21, 1'b0, 8'd6},  // R6 cfg read
        '{2'd2, 14'h2280, 8'h00, 2'b00, 8'h01, 1'b0, 8'd7},  // R7 id bit0
        '{2'd2, 14'h2284, 8'h00, 2'b00, 8'h01, 1'b0, 8'd7},  // R7 id bit1
        '{2'd2, 14'h2288, 8'h00, 2'b00, 8'h00, 1'b0, 8'd7},  // R7 id bit2
        '{2'd2, 14'h228C, 8'h00, 2'b00, 8'h00, 1'b0, 8'd7},  // R7 id bit3
        '{2'd2, 14'h3290, 8'h00, 2'b10, 8'h01, 1'b0, 8'd4},  // R4 ch2 status
        '{2'd2, 14'h1234, 8'h00, 2'b11, 8'h00, 1'b0, 8'd9},  // R9 unmapped
        '{2'd2, 14'h2290, 8'h00, 2'b00, 8'h00, 1'b0, 8'd4}   // R4 no req
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  drv_req = '0;
    logic        card_irq, dma_sel, ext_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    drvirq_ctrl i_drvirq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_req(drv_req),
        .card_irq(card_irq), .dma_sel(dma_sel), .ext_en(ext_en)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // drive one access at a negedge; returns after the next negedge with strobes low
    task automatic access(input int op, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (op == OP_WR);
        bus_rd    = (op == OP_RD);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        drv_req = 2'b11;
        @(negedge clk);
        chk("R1 card_irq", card_irq, 0);
        chk("R1 dma_sel", dma_sel, 0);
        chk("R1 ext_en", ext_en, 0);
        chk("R1 rdata", bus_rdata, 0);
        access(OP_RD, 14'h0000, 8'h00);
        chk("R1 cfg", bus_rdata, 0);

        foreach (VEC[i]) begin
            drv_req = VEC[i].req;
            access(int'(VEC[i].op), VEC[i].addr, VEC[i].wd);
            chk($sformatf("R%0d vec%0d irq", VEC[i].rq, i), card_irq, VEC[i].eirq);
            if (VEC[i].op == 2'd2)
                chk($sformatf("R%0d vec%0d rdata", VEC[i].rq, i), bus_rdata, VEC[i].erd);
        end

        // R6: output bits and restore
        chk("R6 dma_sel", dma_sel, 1);
        chk("R6 ext_en", ext_en, 1);
        access(OP_WR, 14'h0000, 8'h20);
        chk("R6 dma_sel ch1", dma_sel, 0);
        chk("R6 ext_en set", ext_en, 1);
        access(OP_WR, 14'h0000, 8'h00);
        chk("R6 restore ext", ext_en, 0);
        chk("R6 restore dma", dma_sel, 0);

        // R8: request rises with the disabling read
        drv_req = 2'b00;
        access(OP_WR, 14'h2200, 8'h00);
        @(negedge clk);
        bus_addr = 14'h2200;
        bus_rd   = 1'b1;
        drv_req  = 2'b01;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 irq low", card_irq, 0);
        access(OP_RD, 14'h2290, 8'h00);
        chk("R8 status", bus_rdata, 1);

        // R9: unmapped read does not disturb enable or cfg
        access(OP_WR, 14'h2200, 8'h00);
        access(OP_WR, 14'h0000, 8'h5A);
        access(OP_RD, 14'h2204, 8'h00);
        chk("R9 rdata", bus_rdata, 0);
        chk("R9 enable kept", card_irq, 1);
        access(OP_RD, 14'h0000, 8'h00);
        chk("R9 cfg kept", bus_rdata, 8'h5A);
        // write to status address has no effect on enable either
        access(OP_WR, 14'h2290, 8'hFF);
        chk("R9 status write", card_irq, 1);

        // R10: both strobes on an enable address count as a write
        access(OP_RD, 14'h3200, 8'h00);
        drv_req = 2'b10;
        @(negedge clk);
        chk("R10 pre", card_irq, 0);
        bus_addr = 14'h3200;
        bus_wr = 1'b1;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        chk("R10 enabled", card_irq, 1);

        // R1: reset from a busy state
        drv_req = 2'b11;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset irq", card_irq, 0);
        chk("R1 re-reset dma", dma_sel, 0);
        chk("R1 re-reset rdata", bus_rdata, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule